// File: doc/BRIEF.md
# Serial Two-Wire Memory Target Engine

This block is the bus side of a small serial memory of 128 bytes. It watches the SCL and SDA lines of an I2C bus with a fast system clock. It finds Start and Stop conditions and takes in the control byte. It answers only when the device code and the three chip-select pins match. The pin side is an open-drain model: the line level comes in on `sda_i`, and `sda_oe` high pulls the line low.

A write transaction loads the word address into the internal pointer. Each data byte after it goes out on a one-cycle write strobe, together with the address it belongs to. A one-cycle strobe also marks a Stop that closes a write carrying data, so the page-buffer block next to this one can start its program cycle. While that block holds `busy` high, the engine acknowledges nothing, and a master can poll its own address to see when the write is done.

Reads use a synchronous read port: the engine presents the pointer as an address and takes the byte one clock later. The engine supports three reads. A current-address read starts at the pointer. A random read sets the pointer in a write phase and then sends a repeated Start. A sequential read goes on for as long as the master acknowledges.

Top module: `eei2c_target`

## Requirements
- R1: A Start (SDA falling while SCL is high) at any bit position aborts the byte in progress and restarts control-byte reception. A Stop (SDA rising while SCL is high) returns the engine to idle with SDA released. After reset, `sda_oe`, `wr_valid` and `wr_stop` are 0 and `rd_addr` is 0.
- R2: A control byte whose bits 7..4 are 1010 and whose bits 3..1 equal `cs_pins[2:0]` is acknowledged. Bit 0 = 1 selects a read and 0 selects a write. The acknowledge holds `sda_oe` high across the whole high phase of the ninth clock.
- R3: A control byte with a wrong device code or wrong chip-select bits gets no acknowledge. All later bytes are ignored until the next Start: no acknowledge and no write strobe.
- R4: While `busy` is 1, no byte is acknowledged, including a matching control byte. The same control byte is acknowledged once `busy` is 0.
- R5: In a write, the byte after the control byte loads the pointer. Each later byte is acknowledged and produces a one-cycle `wr_valid` with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: After each write data byte, only the low 4 pointer bits increment. The pointer wraps inside its 16-byte page, so a write starting at 0x2E uses 0x2E, 0x2F, 0x20, 0x21.
- R7: A Stop gives a one-cycle `wr_stop` pulse if the write transaction received at least one data byte. No pulse follows an address-only write, a read, or an ignored transaction.
- R8: A read with no preceding word address returns the byte at the pointer, which is one past the last byte read.
- R9: A repeated Start after the word address of a write makes the following read begin at that address.
- R10: Data bytes go out most significant bit first. While the master acknowledges, the following byte is sent. The pointer increments after each read byte across the full array and wraps from 0x7F to 0x00.
- R11: After the master does not acknowledge a read byte, the engine releases SDA and drives nothing on later clocks until the next Start.
- R12: `sda_oe` changes only in the system cycle after a detected SCL falling edge, or after a Start or Stop. It never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cs_pins | input | 3 | Chip-select strap levels |
| busy | input | 1 | Internal write cycle in progress |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 7 | Address for the write byte |
| wr_data | output | 8 | Received write byte |
| wr_stop | output | 1 | One-cycle strobe: Stop ended a write with data |
| rd_addr | output | 7 | Read-port address (the pointer) |
| rd_data | input | 8 | Read-port data, valid one clock after `rd_addr` |

## Verification
A wrong bit counter or state shows at the ports within one byte. It appears as an acknowledge in the wrong clock, a missing acknowledge, or a read byte shifted by one bit. A wrong pointer stays hidden on writes until the same data is read back. It then shows as a wrong byte in the first read of that region, and a page-wrap or array-wrap fault shows in the byte read just after the boundary. A missed Start or Stop shows in the next transaction as a dropped acknowledge or a missing `wr_stop` pulse.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_READ
  } bus_state_t;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
endpackage

// File: rtl/eei2c_line_sync.sv
module eei2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~prev;
  assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/eei2c_addr_ptr.sv
module eei2c_addr_ptr #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_full,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;

  logic [ADDR_W-1:0] ptr_inc;
  assign ptr_inc = ptr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)            ptr <= '0;
    else if (load)      ptr <= load_val;
    else if (step_page) ptr <= (ptr & ~PAGE_MASK) | (ptr_inc & PAGE_MASK);
    else if (step_full) ptr <= ptr_inc;
  end

  // R5: word address lands in the pointer
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    load |=> ptr == $past(load_val));
  // R6: page step keeps the page number
  a_r6_page_kept: assert property (@(posedge clk) disable iff (rst)
    (step_page && !load) |=> ((ptr & ~PAGE_MASK) == $past(ptr & ~PAGE_MASK)));
  // R10: read step wraps across the whole array
  a_r10_full_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_full && !load && !step_page && ptr == TOP_ADDR) |=> ptr == '0);
endmodule

// File: rtl/eei2c_target.sv
module eei2c_target
  import eei2c_pkg::*;
#(
  parameter int          ADDR_W      = 7,
  parameter int          PAGE_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        cs_pins,
  input  logic              busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_stop,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_W + 1);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  eei2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
  eei2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  logic start, stop;
  assign start = scl_lvl & sda_fall;
  assign stop  = scl_lvl & sda_rise;

  bus_state_t       st;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg, txreg;
  logic             is_rd, had_data, mack;
  logic [ADDR_W-1:0] ptr;

  logic       edge_ok, byte_end, ctrl_hit, byte_ok;
  logic [2:0] tx_idx;
  assign edge_ok  = scl_fall & ~start & ~stop;
  assign byte_end = edge_ok & (bit_cnt == CNT_ACK);
  assign ctrl_hit = (shreg[7:4] == DEV_CODE) & (shreg[3:1] == cs_pins);
  assign byte_ok  = ~busy & ((st != ST_CTRL) | ctrl_hit);
  assign tx_idx   = 3'(4'd7 - bit_cnt);

  logic ptr_load, ptr_page, ptr_full;
  assign ptr_load = byte_end & (st == ST_ADDR) & ~busy;
  assign ptr_page = byte_end & (st == ST_WDATA) & ~busy;
  assign ptr_full = byte_end & (st == ST_READ);

  eei2c_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(shreg[ADDR_W-1:0]),
    .step_page(ptr_page), .step_full(ptr_full), .ptr(ptr));

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txreg    <= '0;
      is_rd    <= 1'b0;
      had_data <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_stop  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      wr_stop  <= 1'b0;
      if (start) begin
        st       <= ST_CTRL;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        had_data <= 1'b0;
      end else if (stop) begin
        wr_stop  <= had_data;
        had_data <= 1'b0;
        st       <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < CNT_ACK) begin
            if (st != ST_READ) shreg <= {shreg[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (bit_cnt == CNT_ACK) begin
            mack    <= ~sda_lvl;
            bit_cnt <= CNT_DONE;
          end
        end else if (scl_fall) begin
          if (st == ST_READ) begin
            if (bit_cnt != '0 && bit_cnt < CNT_ACK) begin
              sda_oe <= ~txreg[tx_idx];
            end else if (bit_cnt == CNT_ACK) begin
              sda_oe <= 1'b0;
            end else if (bit_cnt == CNT_DONE) begin
              if (mack) begin
                txreg   <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= '0;
              end else begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end else if (bit_cnt == CNT_ACK) begin
            if (!byte_ok) begin
              st <= ST_IDLE;
            end else begin
              sda_oe <= 1'b1;
              if (st == ST_CTRL) is_rd <= shreg[0];
              if (st == ST_WDATA) begin
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= shreg;
                had_data <= 1'b1;
              end
            end
          end else if (bit_cnt == CNT_DONE) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            if (st == ST_CTRL) begin
              if (is_rd) begin
                st     <= ST_READ;
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                st <= ST_ADDR;
              end
            end else if (st == ST_ADDR) begin
              st <= ST_WDATA;
            end
          end
        end
      end
    end
  end

  // R1: Start restarts control-byte reception at bit zero
  a_r1_start_restart: assert property (@(posedge clk) disable iff (rst)
    start |=> (st == ST_CTRL && bit_cnt == '0 && !sda_oe));
  // R1: Stop releases the line and idles
  a_r1_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop |=> (st == ST_IDLE && !sda_oe));
  // R4: no acknowledge of the control byte while busy
  a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
    (byte_end && st == ST_CTRL && busy) |=> !sda_oe);
  // R5: write strobe lasts one cycle
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  // R7: stop-after-write strobe lasts one cycle
  a_r7_stop_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_stop |=> !wr_stop);
  // R12: the line driver never moves while synchronized SCL is high
  a_r12_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(start) || $past(stop)));
endmodule

// File: tb/eei2c_target_tb.sv
module eei2c_target_tb_top;
  localparam int Q = 6;
  localparam int H = 12;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, wr_valid, wr_stop;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic sda_bus;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eei2c_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cs_pins(CS), .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_stop(wr_stop), .rd_addr(rd_addr), .rd_data(rd_data));

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] exp_ptr;
  int n_cmp = 0, n_bad = 0;
  int wr_cnt = 0, stop_cnt = 0, drive_hi_scl = 0;
  logic [6:0] last_wr_addr = 7'h00;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (wr_valid) begin
      mem[wr_addr] <= wr_data;
      wr_cnt       <= wr_cnt + 1;
      last_wr_addr <= wr_addr;
    end
    if (wr_stop) stop_cnt <= stop_cnt + 1;
    if (sda_oe != oe_prev && scl_m) drive_hi_scl <= drive_hi_scl + 1;
    oe_prev <= sda_oe;
  end

  function automatic logic [6:0] page_next(input logic [6:0] a);
    return {a[6:4], a[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] ctrl(input logic [2:0] cs, input logic rw);
    return {4'b1010, cs, rw};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(H/2);
    b = sda_bus;  wait_clk(H/2);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic master_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~master_ack);
  endtask

  task automatic do_write(input logic [6:0] a, input int n);
    logic ack;
    logic [7:0] d;
    logic [6:0] ea;
    bus_start();
    put_byte(ctrl(CS, 1'b0), ack); chk("R2 write control ack", ack, 1);
    put_byte({1'b0, a}, ack);      chk("R5 word address ack", ack, 1);
    ea = a;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ack); chk("R5 data ack", ack, 1);
      exp_mem[ea] = d;
      ea = page_next(ea);
    end
    bus_stop();
    exp_ptr = ea;
  endtask

  task automatic do_read(input logic set_addr, input logic [6:0] a, input int n);
    logic ack;
    logic [7:0] d;
    if (set_addr) begin
      bus_start();
      put_byte(ctrl(CS, 1'b0), ack); chk("R9 control ack", ack, 1);
      put_byte({1'b0, a}, ack);      chk("R9 address ack", ack, 1);
      exp_ptr = a;
    end
    bus_start();
    put_byte(ctrl(CS, 1'b1), ack); chk("R2 read control ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i < n - 1);
      chk(set_addr ? "R9/R10 read data" : "R8 current read data", d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 7'd1;
    end
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]     = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    exp_ptr = 7'h00;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack, b;
    logic [7:0] d;
    int w0, s0;
    void'($urandom(32'd7021));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    // R1 reset state
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset wr_valid", wr_valid, 0);
    chk("R1 reset wr_stop", wr_stop, 0);
    chk("R1 reset rd_addr", rd_addr, 0);

    // R3: wrong chip select, then wrong device code
    w0 = wr_cnt; s0 = stop_cnt;
    bus_start();
    put_byte(ctrl(3'b010, 1'b0), ack); chk("R3 cs mismatch no ack", ack, 0);
    put_byte(8'h60, ack);              chk("R3 later byte no ack", ack, 0);
    put_byte(8'h11, ack);              chk("R3 data ignored", ack, 0);
    bus_stop();
    bus_start();
    put_byte({4'b1011, CS, 1'b0}, ack); chk("R3 code mismatch no ack", ack, 0);
    bus_stop();
    chk("R3 no write strobe", wr_cnt, w0);
    chk("R7 no stop strobe after ignored", stop_cnt, s0);

    // R5/R7: plain write of three bytes
    s0 = stop_cnt;
    do_write(7'h10, 3);
    wait_clk(4);
    chk("R7 stop strobe after write", stop_cnt, s0 + 1);
    chk("R5 last write address", last_wr_addr, 7'h12);

    // R9 random read back
    do_read(1'b1, 7'h10, 3);

    // R7 address-only write: no strobe
    s0 = stop_cnt;
    bus_start();
    put_byte(ctrl(CS, 1'b0), ack); chk("R2 ack", ack, 1);
    put_byte(8'h33, ack);          chk("R5 address ack", ack, 1);
    bus_stop();
    wait_clk(4);
    chk("R7 no strobe after address-only write", stop_cnt, s0);
    exp_ptr = 7'h33;

    // R4 busy polling
    busy = 1'b1;
    bus_start();
    put_byte(ctrl(CS, 1'b0), ack); chk("R4 busy no ack", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    put_byte(ctrl(CS, 1'b0), ack); chk("R4 ack after busy", ack, 1);
    bus_stop();

    // R6 page wrap on writes
    do_write(7'h2E, 4);
    wait_clk(4);
    chk("R6 wrapped write address", last_wr_addr, 7'h21);
    do_read(1'b1, 7'h2E, 2);
    do_read(1'b1, 7'h20, 2);

    // R10 sequential read wrapping past the top
    do_read(1'b1, 7'h7E, 4);

    // R11 NACK release, then R8 current-address read
    exp_mem[7'h40] = 8'h5A;
    exp_mem[7'h41] = 8'h00;
    bus_start();
    put_byte(ctrl(CS, 1'b0), ack);
    put_byte(8'h40, ack);
    put_byte(8'h5A, ack);
    put_byte(8'h00, ack); chk("R5 data ack", ack, 1);
    bus_stop();
    do_read(1'b1, 7'h40, 1);
    chk("R11 released after nack", sda_oe, 0);
    bus_start();
    put_byte(ctrl(CS, 1'b1), ack);
    get_byte(d, 1'b0);    chk("R8 current read", d, 8'h00);
    get_bit(b);           chk("R11 no drive after nack", b, 1);
    bus_stop();
    exp_ptr = 7'h42;
    do_read(1'b0, 7'h00, 2);

    // R1 Start aborts a partial byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    put_byte(ctrl(CS, 1'b0), ack); chk("R1 ack after abort", ack, 1);
    put_byte(8'h50, ack);
    put_byte(8'h77, ack);
    bus_stop();
    exp_mem[7'h50] = 8'h77;
    do_read(1'b1, 7'h50, 1);

    // random phase
    for (int k = 0; k < 6; k++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom);
      n = 1 + int'($urandom % 18);
      do_write(a, n);
      do_read(1'b1, {a[6:4], 4'h0}, 16);
    end

    chk("R12 no drive change while SCL high", drive_hi_scl, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule